// File: doc/BRIEF.md
# Tuning Word History Averager

This block sits beside a digital PLL loop filter and builds a long-term record of the frequency tuning word. The loop offers one 48-bit word per sample strobe. The block sums these words over an averaging interval of `ivl_len` samples. At the end of the interval it divides the sum exactly by the sample count and latches the quotient into a history register. A one-cycle update pulse goes out with each latched result. The history register then supplies the holdover frequency when the loop opens. Every interval starts from an empty sum, so each result depends only on its own samples.

History is wiped by reset, by a software clear, by a pin clear, and by a reference switch unless the keep-history option is set. After a wipe, the first interval can publish early averages so that a holdover value exists long before a full interval has passed. The 3-bit `early_k` sets how many of the power-of-two fractions of the interval (T/2, T/4, …, T/2^k) also publish. Each early result is the average of all samples taken since the wipe. An interval length of zero is rejected: no sample is counted and nothing is published.

Top module: `twh_averager`

## Requirements
- R1: After reset, `hist_valid`, `hist_upd` and `hist_ftw` are all zero.
- R2: A published result equals floor(sum / n), where the sum covers the n accepted samples it includes. Cycles with `smp_vld` low add nothing. The result reaches `hist_ftw` on the clock edge after the edge that accepts its last sample. In that same cycle `hist_upd` is high for one cycle and `hist_valid` is high.
- R3: Samples of one completed interval never contribute to a result of a later interval.
- R4: With `early_k` = 0, and in every interval after the first one following a wipe, exactly one result is published, when the T-th sample of the interval is accepted (T = `ivl_len`).
- R5: In the first interval after a wipe with `early_k` = K > 0, a result is also published when the sample count since the wipe equals T >> j, for each j from 1 to K where that value is nonzero. This includes non-power-of-two T, with shifts truncating.
- R6: Early results happen only in that first interval. The following intervals publish only at their T-th sample.
- R7: `clr_sw` or `clr_pin` high in a cycle wipes the history. `hist_valid` is low after the next edge, and the sum, count and early schedule restart.
- R8: `ref_new` with `keep_hist` low acts as a wipe. With `keep_hist` high, `hist_ftw` and `hist_valid` are kept and only the sum and count restart.
- R9: A wipe takes priority over a result. A wipe in the same cycle as the completing sample drops that sample. A wipe in the cycle right after it cancels the pending result. In both cases no `hist_update` pulse occurs and `hist_valid` ends low.
- R10: While `ivl_len` is zero, `ivl_err` is high, samples are not counted and no result is published. Counting resumes normally once the length is nonzero.
- R11: At the largest interval (2^16−1 samples) of full-scale words, no overflow occurs and the average is exact.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| smp_vld | input | 1 | Sample strobe for `smp_ftw` |
| smp_ftw | input | 48 | Instantaneous tuning word from the loop |
| ivl_len | input | 16 | Averaging interval T in samples; zero is illegal |
| early_k | input | 3 | Number of early power-of-two checkpoints after a wipe |
| keep_hist | input | 1 | Keep history across a reference switch |
| ref_new | input | 1 | One-cycle pulse: loop moved to a new reference |
| clr_sw | input | 1 | Software history clear |
| clr_pin | input | 1 | Pin history clear |
| hist_ftw | output | 48 | Latched average tuning word |
| hist_valid | output | 1 | History register holds a result since the last wipe |
| hist_upd | output | 1 | One-cycle pulse per latched result |
| ivl_err | output | 1 | Interval length is zero |

## Verification
A scoreboard predicts every result and its timing, then compares each update pulse against it.

- **Power-of-two assumption.** T = 10 with K = 2 checks checkpoints at 2 and 5. A design that assumed powers of two or shifted instead of dividing would publish at the wrong counts or with wrong values.
- **Tiny checkpoints.** K = 7 with T = 16 makes several checkpoints zero. A design that did not skip them would hang or repeat pulses.
- **Clear on the last sample.** A clear on the completing sample, and a clear one cycle later, must each suppress a result. A design that let the interval end win would publish a stale average.
- **Persistence and range.** A kept-history reference switch must not touch the stored word. A run of 65535 full-scale words exposes any accumulator or divider truncation.

// File: rtl/twh_pkg.sv
package twh_pkg;

  // width of the early-checkpoint selector and its largest value
  localparam int K_W   = 3;
  localparam int K_MAX = (1 << K_W) - 1;

  // what a control cycle does to the running average
  typedef enum logic [1:0] {
    RS_NONE = 2'd0,   // normal operation
    RS_KEEP = 2'd1,   // restart sum and count, keep history
    RS_WIPE = 2'd2    // restart sum and count, drop history
  } restart_e;

  function automatic restart_e restart_kind(input logic wipe_req,
                                            input logic ref_sw,
                                            input logic keep);
    if (wipe_req)    return RS_WIPE;
    else if (ref_sw) return keep ? RS_KEEP : RS_WIPE;
    else             return RS_NONE;
  endfunction

endpackage

// File: rtl/twh_sched.sv
module twh_sched
  import twh_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             smp_vld,
  input  logic [CNT_W-1:0] ivl_len,
  input  logic [K_W-1:0]   early_k,
  input  restart_e         rs,
  output logic             take,
  output logic [CNT_W-1:0] n_now,
  output logic             pub,
  output logic             ivl_end
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             first_q, first_d;
  logic             cnt_en;
  logic [K_MAX:1]   hit;

  // a sample counts only with a legal length and no restart in the cycle
  assign take    = smp_vld && (ivl_len != '0) && (rs == RS_NONE);
  assign n_now   = cnt_q + 1'b1;
  assign ivl_end = take && (n_now >= ivl_len);

  // one comparator per possible early checkpoint T >> j
  generate
    for (genvar j = 1; j <= K_MAX; j++) begin : g_cp
      assign hit[j] = (early_k >= K_W'(j)) && (n_now == (ivl_len >> j));
    end
  endgenerate

  assign pub = ivl_end || (take && first_q && (|hit));

  always_comb begin
    cnt_d   = cnt_q;
    first_d = first_q;
    cnt_en  = 1'b0;
    unique case (rs)
      RS_WIPE: begin
        cnt_d   = '0;
        first_d = 1'b1;
        cnt_en  = 1'b1;
      end
      RS_KEEP: begin
        cnt_d  = '0;
        cnt_en = 1'b1;
      end
      default: begin
        if (take) begin
          cnt_en = 1'b1;
          if (ivl_end) begin
            cnt_d   = '0;
            first_d = 1'b0;
          end else begin
            cnt_d = n_now;
          end
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      first_q <= 1'b1;
    end else if (cnt_en) begin
      cnt_q   <= cnt_d;
      first_q <= first_d;
    end
  end

  // R4
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((ivl_len != '0) && $stable(ivl_len) && ($past(cnt_q) < ivl_len))
      |-> (cnt_q < ivl_len));

endmodule

// File: rtl/twh_accum.sv
module twh_accum
  import twh_pkg::*;
#(
  parameter int FTW_W = 48,
  parameter int CNT_W = 16,
  localparam int ACC_W = FTW_W + CNT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  restart_e         rs,
  input  logic             take,
  input  logic             ivl_end,
  input  logic [FTW_W-1:0] ftw,
  output logic [ACC_W-1:0] sum_now
);

  logic [ACC_W-1:0] acc_q, acc_d;
  logic             acc_en;

  // the sum including the word offered this cycle
  assign sum_now = acc_q + {{CNT_W{1'b0}}, ftw};

  always_comb begin
    acc_en = 1'b0;
    acc_d  = acc_q;
    if (rs != RS_NONE) begin
      acc_en = 1'b1;
      acc_d  = '0;
    end else if (take) begin
      acc_en = 1'b1;
      acc_d  = ivl_end ? '0 : sum_now;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      acc_q <= '0;
    else if (acc_en) acc_q <= acc_d;
  end

  // R11
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !ivl_end) |=> (acc_q >= $past(acc_q)));

endmodule

// File: rtl/twh_hist.sv
module twh_hist #(
  parameter int FTW_W = 48,
  parameter int CNT_W = 16,
  localparam int ACC_W = FTW_W + CNT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pub,
  input  logic             wipe,
  input  logic [ACC_W-1:0] sum_now,
  input  logic [CNT_W-1:0] n_now,
  output logic [FTW_W-1:0] hist_ftw,
  output logic             hist_valid,
  output logic             hist_upd
);

  // snapshot stage
  logic             snap_vld_q;
  logic [ACC_W-1:0] snap_sum_q;
  logic [CNT_W-1:0] snap_n_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) snap_vld_q <= 1'b0;
    else        snap_vld_q <= pub;
  end

  always_ff @(posedge clk) begin
    if (pub) begin
      snap_sum_q <= sum_now;
      snap_n_q   <= n_now;
    end
  end

  // restoring divider: the upper CNT_W bits of the sum are below n,
  // so FTW_W quotient bits cover every average
  logic [CNT_W-1:0] rem [0:FTW_W];
  logic [FTW_W-1:0] quo;

  assign rem[0] = snap_sum_q[ACC_W-1 -: CNT_W];

  generate
    for (genvar i = 0; i < FTW_W; i++) begin : g_div
      logic [CNT_W:0] part;
      logic           ge;
      assign part = {rem[i], snap_sum_q[FTW_W-1-i]};
      assign ge   = (part >= {1'b0, snap_n_q});
      assign quo[FTW_W-1-i] = ge;
      assign rem[i+1] = ge ? CNT_W'(part - {1'b0, snap_n_q}) : CNT_W'(part);
    end
  endgenerate

  // history stage
  logic             upd_d, valid_d, ftw_en;
  logic [FTW_W-1:0] ftw_q;
  logic             valid_q, upd_q;

  always_comb begin
    upd_d   = snap_vld_q && !wipe;
    ftw_en  = upd_d;
    valid_d = wipe ? 1'b0 : (snap_vld_q || valid_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ftw_q   <= '0;
      valid_q <= 1'b0;
      upd_q   <= 1'b0;
    end else begin
      valid_q <= valid_d;
      upd_q   <= upd_d;
      if (ftw_en) ftw_q <= quo;
    end
  end

  assign hist_ftw   = ftw_q;
  assign hist_valid = valid_q;
  assign hist_upd   = upd_q;

  // R2
  upd_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hist_upd |-> hist_valid);

  // R9
  wipe_kill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wipe |=> (!hist_upd && !hist_valid));

  // R11
  rem_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    snap_vld_q |-> (rem[FTW_W] < snap_n_q));

endmodule

// File: rtl/twh_averager.sv
module twh_averager
  import twh_pkg::*;
#(
  parameter int FTW_W = 48,
  parameter int CNT_W = 16,
  localparam int ACC_W = FTW_W + CNT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             smp_vld,
  input  logic [FTW_W-1:0] smp_ftw,
  input  logic [CNT_W-1:0] ivl_len,
  input  logic [K_W-1:0]   early_k,
  input  logic             keep_hist,
  input  logic             ref_new,
  input  logic             clr_sw,
  input  logic             clr_pin,
  output logic [FTW_W-1:0] hist_ftw,
  output logic             hist_valid,
  output logic             hist_upd,
  output logic             ivl_err
);

  // asynchronous assert, synchronous release
  logic [1:0] rst_pipe;
  logic       rst_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_s = rst_pipe[1];

  restart_e         rs;
  logic             take, pub, ivl_end;
  logic [CNT_W-1:0] n_now;
  logic [ACC_W-1:0] sum_now;

  assign rs      = restart_kind(clr_sw || clr_pin, ref_new, keep_hist);
  assign ivl_err = (ivl_len == '0);

  twh_sched #(.CNT_W(CNT_W)) u_sched (
    .clk     (clk),
    .rst_n   (rst_s),
    .smp_vld (smp_vld),
    .ivl_len (ivl_len),
    .early_k (early_k),
    .rs      (rs),
    .take    (take),
    .n_now   (n_now),
    .pub     (pub),
    .ivl_end (ivl_end)
  );

  twh_accum #(.FTW_W(FTW_W), .CNT_W(CNT_W)) u_accum (
    .clk     (clk),
    .rst_n   (rst_s),
    .rs      (rs),
    .take    (take),
    .ivl_end (ivl_end),
    .ftw     (smp_ftw),
    .sum_now (sum_now)
  );

  twh_hist #(.FTW_W(FTW_W), .CNT_W(CNT_W)) u_hist (
    .clk        (clk),
    .rst_n      (rst_s),
    .pub        (pub),
    .wipe       (rs == RS_WIPE),
    .sum_now    (sum_now),
    .n_now      (n_now),
    .hist_ftw   (hist_ftw),
    .hist_valid (hist_valid),
    .hist_upd   (hist_upd)
  );

  // R10
  zero_ivl_chk: assert property (@(posedge clk) disable iff (!rst_s)
    ($past(ivl_len, 2) == '0) |-> !hist_upd);

  // R8
  keep_hist_chk: assert property (@(posedge clk) disable iff (!rst_s)
    ($past(ref_new) && $past(keep_hist) && !$past(clr_sw) && !$past(clr_pin))
      |-> (hist_valid || !$past(hist_valid)));

endmodule

// File: tb/tb_twh_averager.sv
module tb_twh_averager;

  localparam int FTW_W = 48;
  localparam int CNT_W = 16;
  localparam logic [FTW_W-1:0] FULL = '1;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic             rst_n, smp_vld, keep_hist, ref_new, clr_sw, clr_pin;
  logic [FTW_W-1:0] smp_ftw;
  logic [CNT_W-1:0] ivl_len;
  logic [2:0]       early_k;
  logic [FTW_W-1:0] hist_ftw;
  logic             hist_valid, hist_upd, ivl_err;

  twh_averager dut (
    .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .smp_ftw(smp_ftw),
    .ivl_len(ivl_len), .early_k(early_k), .keep_hist(keep_hist),
    .ref_new(ref_new), .clr_sw(clr_sw), .clr_pin(clr_pin),
    .hist_ftw(hist_ftw), .hist_valid(hist_valid), .hist_upd(hist_upd),
    .ivl_err(ivl_err)
  );

  int n_chk = 0, n_bad = 0, upd_cnt = 0;
  bit done = 0;
  logic [FTW_W-1:0] exp_q[$];

  // reference model state
  logic [63:0] m_sum = '0;
  int          m_n = 0;
  bit          m_first = 1, m_pushed = 0;

  task automatic check(input bit ok, input string req,
                       input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic model_step(input logic [FTW_W-1:0] w);
    bit pub;
    m_n++;
    m_sum = m_sum + {16'b0, w};
    pub = (m_n >= int'(ivl_len));
    if (m_first)
      for (int j = 1; j <= int'(early_k); j++)
        if (m_n == int'(ivl_len >> j)) pub = 1;
    if (pub) begin
      exp_q.push_back(FTW_W'(m_sum / 64'(m_n)));
      m_pushed = 1;
    end
    if (m_n >= int'(ivl_len)) begin
      m_sum = '0; m_n = 0; m_first = 0;
    end
  endtask

  // driver: one cycle of stimulus plus the expected effect
  task automatic cyc(input bit v, input logic [FTW_W-1:0] w,
                     input bit csw = 0, input bit cpin = 0, input bit rnew = 0);
    @(posedge clk); #1;
    smp_vld = v; smp_ftw = w; clr_sw = csw; clr_pin = cpin; ref_new = rnew;
    if (csw || cpin || (rnew && !keep_hist)) begin
      if (m_pushed) void'(exp_q.pop_back());
      m_sum = '0; m_n = 0; m_first = 1; m_pushed = 0;
    end else if (rnew) begin
      m_sum = '0; m_n = 0; m_pushed = 0;
    end else begin
      m_pushed = 0;
      if (v && ivl_len != '0) model_step(w);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(0, '0);
  endtask

  task automatic expect_strobes(input int n, input string req);
    idle(4);
    check(upd_cnt == n, req, 64'(upd_cnt), 64'(n));
    check(exp_q.size() == 0, req, 64'(exp_q.size()), 64'd0);
    upd_cnt = 0;
  endtask

  // monitor: compares each update against the scoreboard
  always @(negedge clk) begin
    if (rst_n && !done && hist_upd) begin
      logic [FTW_W-1:0] e;
      upd_cnt++;
      if (exp_q.size() == 0) begin
        check(0, "R2 unexpected update", 64'(hist_ftw), 64'd0);
      end else begin
        e = exp_q.pop_front();
        check(hist_ftw == e, "R2 average value", 64'(hist_ftw), 64'(e));
        check(hist_valid, "R2 valid with update", 64'(hist_valid), 64'd1);
      end
    end
  end

  task automatic summary;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL R2 watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  logic [FTW_W-1:0] kept;

  initial begin
    rst_n = 0; smp_vld = 0; smp_ftw = '0; ivl_len = 16'd8; early_k = 3'd0;
    keep_hist = 0; ref_new = 0; clr_sw = 0; clr_pin = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    idle(4);

    // R1 reset state
    check(hist_valid == 0, "R1 valid", 64'(hist_valid), 64'd0);
    check(hist_upd == 0, "R1 update", 64'(hist_upd), 64'd0);
    check(hist_ftw == '0, "R1 word", 64'(hist_ftw), 64'd0);
    check(ivl_err == 0, "R10 err low", 64'(ivl_err), 64'd0);

    // R4 / R3: K=0, T=8, gaps between samples, two intervals
    for (int i = 0; i < 7; i++) begin
      cyc(1, 48'(100 + i * 7));
      if (i % 3 == 0) idle(1);
    end
    idle(3);
    check(upd_cnt == 0, "R4 no early result", 64'(upd_cnt), 64'd0);
    cyc(1, 48'd999);
    for (int i = 0; i < 8; i++) cyc(1, 48'(5000 + i * 3));
    expect_strobes(2, "R3 R4 interval count");
    check(hist_valid == 1, "R2 valid held", 64'(hist_valid), 64'd1);

    // R7 software clear, then R5 / R6: K=3, T=16
    cyc(0, '0, 1);
    idle(1);
    check(hist_valid == 0, "R7 clear via clr_sw", 64'(hist_valid), 64'd0);
    ivl_len = 16'd16; early_k = 3'd3;
    for (int i = 0; i < 32; i++) cyc(1, 48'h1000_0000 + 48'(i * i * 37));
    expect_strobes(5, "R5 R6 early schedule K3");

    // R7 pin clear, R5 non-power-of-two T=10, K=2
    cyc(0, '0, 0, 1);
    idle(1);
    check(hist_valid == 0, "R7 clear via clr_pin", 64'(hist_valid), 64'd0);
    ivl_len = 16'd10; early_k = 3'd2;
    for (int i = 0; i < 20; i++) cyc(1, 48'(77777 * (i + 1)));
    expect_strobes(4, "R5 T10 K2");

    // R5 zero checkpoints skipped: K=7, T=16; R6 next interval
    cyc(0, '0, 1);
    ivl_len = 16'd16; early_k = 3'd7;
    for (int i = 0; i < 16; i++) cyc(1, 48'h0ABC_0000_0000 - 48'(i * 4099));
    expect_strobes(5, "R5 K7 T16");
    for (int i = 0; i < 16; i++) cyc(1, 48'(i * 11));
    expect_strobes(1, "R6 later interval plain");

    // R9 clear priority
    early_k = 3'd0; ivl_len = 16'd4;
    cyc(0, '0, 1);
    for (int i = 0; i < 3; i++) cyc(1, 48'(i + 50));
    cyc(1, 48'd60, 1);
    expect_strobes(0, "R9 clear with last sample");
    check(hist_valid == 0, "R9 valid low", 64'(hist_valid), 64'd0);
    for (int i = 0; i < 4; i++) cyc(1, 48'(i + 70));
    cyc(0, '0, 1);
    expect_strobes(0, "R9 clear after last sample");
    check(hist_valid == 0, "R9 pending dropped", 64'(hist_valid), 64'd0);
    for (int i = 0; i < 4; i++) cyc(1, 48'(i * 1000 + 3));
    expect_strobes(1, "R9 recovery");

    // R8 reference switch, wiping then keeping
    cyc(0, '0, 0, 0, 1);
    idle(1);
    check(hist_valid == 0, "R8 switch wipes", 64'(hist_valid), 64'd0);
    for (int i = 0; i < 4; i++) cyc(1, 48'(i * 9 + 400));
    expect_strobes(1, "R8 after wipe");
    kept = hist_ftw;
    keep_hist = 1;
    cyc(1, 48'hFFFF_0000_0000); cyc(1, 48'hFFFF_0000_0000);
    cyc(0, '0, 0, 0, 1);
    idle(2);
    check(hist_valid == 1, "R8 keep valid", 64'(hist_valid), 64'd1);
    check(hist_ftw == kept, "R8 keep word", 64'(hist_ftw), 64'(kept));
    for (int i = 0; i < 4; i++) cyc(1, 48'(i + 20));
    expect_strobes(1, "R8 restart after keep");
    keep_hist = 0;

    // R10 zero length
    cyc(0, '0, 1);
    ivl_len = 16'd0;
    idle(1);
    check(ivl_err == 1, "R10 err high", 64'(ivl_err), 64'd1);
    for (int i = 0; i < 10; i++) cyc(1, 48'(i + 1));
    expect_strobes(0, "R10 nothing stored");
    check(hist_valid == 0, "R10 valid low", 64'(hist_valid), 64'd0);
    ivl_len = 16'd4;
    #1 check(ivl_err == 0, "R10 err cleared", 64'(ivl_err), 64'd0);
    for (int i = 0; i < 4; i++) cyc(1, 48'(i * 5));
    expect_strobes(1, "R10 resumes");

    // R11 full scale
    cyc(0, '0, 1);
    ivl_len = 16'd16;
    for (int i = 0; i < 16; i++) cyc(1, (i % 2 == 0) ? FULL : FULL - 48'd1);
    expect_strobes(1, "R11 alternating full scale");
    ivl_len = 16'hFFFF;
    for (int i = 0; i < 65535; i++) cyc(1, FULL);
    expect_strobes(1, "R11 max interval");
    check(hist_ftw == FULL, "R11 exact average", 64'(hist_ftw), 64'(FULL));

    done = 1;
    summary();
    $finish;
  end

endmodule